// File: doc/BRIEF.md
# Banked Block Copy Sequencer

This block copies a run of bytes from one 24-bit memory region to another. Each address is an 8-bit bank joined to a 16-bit offset. A start pulse captures five values: the source offset, the destination offset, a length field holding the byte count minus one, the source bank and the destination bank. A direction select also arrives with the pulse. The sequencer then moves the bytes one at a time over a synchronous byte-wide memory port. Each byte takes one read cycle and then one write cycle. The memory stretches any cycle by holding its ready input low.

The direction select decides whether both offsets step upward or downward after each byte. This lets overlapping regions be copied safely. A caller picks the downward order when the destination lies above the source, and the upward order otherwise. Offsets wrap inside their bank, and the bank never changes during a move.

When the length field passes below zero the move is over. The sequencer then raises a one-cycle completion pulse. It also presents the final offsets, the final length field and the destination bank, so a register file can write them back.

Top module: `block_mover`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are 0, and `x_out`, `y_out`, `c_out` and `dbank_out` are all zero.
- R2: A `start` pulse while idle loads the operands. The first memory access of the move is a read at address {`src_bank`, `x_in`}.
- R3: Every byte is a read at {source bank, current source offset}, with `mem_we`=0. It is followed by a write at {destination bank, current destination offset}, with `mem_we`=1 and `mem_wdata` equal to the byte just read.
- R4: When `descend`=0, both offsets increase by 1 after each written byte. When `descend`=1, both decrease by 1. In each direction, overlapping regions copy correctly in the matching direction (upward when destination < source, downward when destination > source).
- R5: A length field of N moves exactly N+1 bytes. A length field of 0 moves one byte.
- R6: `done` is high for exactly one cycle, in the cycle after the final write is accepted. `busy` is low in that cycle.
- R7: At `done`, `x_out` and `y_out` equal their start values plus (upward) or minus (downward) N+1, modulo 2^16, and `c_out` = 0xFFFF.
- R8: At `done`, `dbank_out` equals the destination bank of the finished move.
- R9: While `mem_req`=1 and `mem_ready`=0, the request, address, write enable and write data stay unchanged into the next cycle.
- R10: A `start` pulse while `busy` is ignored. The move in progress finishes with its own operands.
- R11: An offset that steps past 0xFFFF (or below 0x0000) wraps within its bank. Reads always use the source bank and writes always use the destination bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a move (accepted only while idle) |
| descend | input | 1 | 1 = offsets step downward, 0 = upward |
| src_bank | input | 8 | Source bank |
| dst_bank | input | 8 | Destination bank |
| x_in | input | 16 | Source start offset |
| y_in | input | 16 | Destination start offset |
| c_in | input | 16 | Byte count minus one |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle completion pulse |
| x_out | output | 16 | Current / final source offset |
| y_out | output | 16 | Current / final destination offset |
| c_out | output | 16 | Current / final length field |
| dbank_out | output | 8 | Destination bank of the last finished move |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | 1 = write cycle, 0 = read cycle |
| mem_addr | output | 24 | Byte address {bank, offset} |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid when `mem_ready`=1 on a read |
| mem_ready | input | 1 | Current cycle completes at this clock edge |

## Verification
The first read address appears one clock edge after `start` is sampled. `done`, the final offsets, the length field and `dbank_out` all change at the edge that accepts the final write. The bench drives inputs and samples outputs on falling edges. It waits for `done` on a falling edge and compares the final values right there. It checks one falling edge later that `done` has dropped. The memory model answers with an irregular ready pattern and records every accepted cycle at the rising edge. From that record it checks the bank, the access count, the first read address and whether a stalled request stayed unchanged. It compares the final memory image against a byte-by-byte copy computed in the bench.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef enum logic [1:0] {
    BM_IDLE  = 2'd0,
    BM_READ  = 2'd1,
    BM_WRITE = 2'd2
  } bm_state_e;
endpackage

// File: rtl/bm_ptr.sv
module bm_ptr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic         down,
  input  logic [W-1:0] init,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= init;
    else if (step) q <= down ? q - ONE : q + ONE;
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (q == ($past(down) ? $past(q) - ONE : $past(q) + ONE))); // R4
endmodule

// File: rtl/bm_cnt.sv
module bm_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] init,
  output logic [W-1:0] q,
  output logic         last
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= init;
    else if (step) q <= q - ONE;
  end

  assign last = (q == '0);

  AST_CNT_DEC: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (q == $past(q) - ONE)); // R5
endmodule

// File: rtl/bm_ctrl.sv
module bm_ctrl
  import bm_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int OFS_W  = 16,
  parameter int DATA_W = 8,
  localparam int ADDR_W = BANK_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              descend,
  input  logic [BANK_W-1:0] src_bank,
  input  logic [BANK_W-1:0] dst_bank,
  input  logic [OFS_W-1:0]  x_q,
  input  logic [OFS_W-1:0]  y_q,
  input  logic              last,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              load,
  output logic              step,
  output logic              dir_q,
  output logic              busy,
  output logic              done,
  output logic [BANK_W-1:0] dbank_out,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  bm_state_e         state;
  logic [BANK_W-1:0] sb_q, db_q;
  logic [DATA_W-1:0] data_q;
  logic              finish;

  assign load   = (state == BM_IDLE) && start;
  assign step   = (state == BM_WRITE) && mem_ready;
  assign finish = step && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= BM_IDLE;
      sb_q      <= '0;
      db_q      <= '0;
      dir_q     <= 1'b0;
      data_q    <= '0;
      done      <= 1'b0;
      dbank_out <= '0;
    end else begin
      done <= finish;
      unique case (state)
        BM_IDLE: if (start) begin
          sb_q  <= src_bank;
          db_q  <= dst_bank;
          dir_q <= descend;
          state <= BM_READ;
        end
        BM_READ: if (mem_ready) begin
          data_q <= mem_rdata;
          state  <= BM_WRITE;
        end
        BM_WRITE: if (mem_ready) begin
          if (last) begin
            state     <= BM_IDLE;
            dbank_out <= db_q;
          end else begin
            state <= BM_READ;
          end
        end
        default: state <= BM_IDLE;
      endcase
    end
  end

  assign busy      = (state != BM_IDLE);
  assign mem_req   = busy;
  assign mem_we    = (state == BM_WRITE);
  assign mem_addr  = (state == BM_WRITE) ? {db_q, y_q} : {sb_q, x_q};
  assign mem_wdata = data_q;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R9
  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ready && !mem_we) |=> (mem_req && mem_we)); // R3
  AST_DONE_ONCE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R6
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(sb_q) && $stable(db_q) && $stable(dir_q))); // R10
endmodule

// File: rtl/block_mover.sv
module block_mover #(
  parameter int BANK_W = 8,
  parameter int OFS_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic                      descend,
  input  logic [BANK_W-1:0]         src_bank,
  input  logic [BANK_W-1:0]         dst_bank,
  input  logic [OFS_W-1:0]          x_in,
  input  logic [OFS_W-1:0]          y_in,
  input  logic [OFS_W-1:0]          c_in,
  output logic                      busy,
  output logic                      done,
  output logic [OFS_W-1:0]          x_out,
  output logic [OFS_W-1:0]          y_out,
  output logic [OFS_W-1:0]          c_out,
  output logic [BANK_W-1:0]         dbank_out,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [BANK_W+OFS_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]         mem_wdata,
  input  logic [DATA_W-1:0]         mem_rdata,
  input  logic                      mem_ready
);
  logic load, step, dir_q, last;

  bm_ctrl #(.BANK_W(BANK_W), .OFS_W(OFS_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .descend(descend),
    .src_bank(src_bank), .dst_bank(dst_bank),
    .x_q(x_out), .y_q(y_out), .last(last),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .load(load), .step(step), .dir_q(dir_q),
    .busy(busy), .done(done), .dbank_out(dbank_out),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  bm_ptr #(.W(OFS_W)) u_src_ptr (
    .clk(clk), .rst(rst), .load(load), .step(step), .down(dir_q),
    .init(x_in), .q(x_out)
  );

  bm_ptr #(.W(OFS_W)) u_dst_ptr (
    .clk(clk), .rst(rst), .load(load), .step(step), .down(dir_q),
    .init(y_in), .q(y_out)
  );

  bm_cnt #(.W(OFS_W)) u_len (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .init(c_in), .q(c_out), .last(last)
  );

  AST_END_WRAP: assert property (@(posedge clk) disable iff (rst)
    done |-> (c_out == '1)); // R7
endmodule

// File: tb/sim_block_mover.sv
`timescale 1ns/1ps
module sim_block_mover;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, descend = 1'b0;
  logic [7:0]  src_bank = '0, dst_bank = '0;
  logic [15:0] x_in = '0, y_in = '0, c_in = '0;
  logic        busy, done, mem_req, mem_we;
  logic [15:0] x_out, y_out, c_out;
  logic [7:0]  dbank_out, mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ready = 1'b0;
  logic [23:0] mem_addr;

  always #5 clk = ~clk;

  block_mover u0 (
    .clk(clk), .rst(rst), .start(start), .descend(descend),
    .src_bank(src_bank), .dst_bank(dst_bank),
    .x_in(x_in), .y_in(y_in), .c_in(c_in),
    .busy(busy), .done(done), .x_out(x_out), .y_out(y_out), .c_out(c_out),
    .dbank_out(dbank_out), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: 4096 bytes indexed by {bank[1:0], offset[9:0]}
  logic [7:0] mem [0:4095];
  logic [7:0] ref_mem [0:4095];
  function automatic int idx(input logic [7:0] b, input logic [15:0] o);
    return {b[1:0], o[9:0]};
  endfunction

  logic [2:0]  cyc = '0;
  int          rd_cnt = 0, bank_err = 0, stall_err = 0;
  logic [23:0] first_rd = '0;
  logic [7:0]  cur_sb = '0, cur_db = '0;
  logic        prev_stall = 1'b0, prev_we = 1'b0;
  logic [23:0] prev_addr = '0;
  logic [7:0]  prev_wd = '0;

  always @(negedge clk) begin
    cyc       <= cyc + 3'd1;
    mem_ready <= !(cyc == 3'd1 || cyc == 3'd2 || cyc == 3'd5);
    mem_rdata <= mem[idx(mem_addr[23:16], mem_addr[15:0])];
  end

  always @(posedge clk) begin
    if (prev_stall && (!mem_req || mem_addr != prev_addr || mem_we != prev_we || mem_wdata != prev_wd))
      stall_err <= stall_err + 1;
    prev_stall <= mem_req && !mem_ready;
    prev_addr  <= mem_addr;
    prev_we    <= mem_we;
    prev_wd    <= mem_wdata;
    if (mem_req && mem_ready) begin
      if (mem_we) begin
        mem[idx(mem_addr[23:16], mem_addr[15:0])] <= mem_wdata;
        if (mem_addr[23:16] != cur_db) bank_err <= bank_err + 1;
      end else begin
        if (rd_cnt == 0) first_rd <= mem_addr;
        rd_cnt <= rd_cnt + 1;
        if (mem_addr[23:16] != cur_sb) bank_err <= bank_err + 1;
      end
    end
  end

  // vector: [64] descend, [63:56] src bank, [55:48] dst bank, [47:32] x, [31:16] y, [15:0] length-1
  localparam int NV = 6;
  localparam logic [64:0] VEC [NV] = '{
    {1'b0, 8'h01, 8'h02, 16'h0010, 16'h0020, 16'h0007},
    {1'b0, 8'h00, 8'h00, 16'h0100, 16'h0080, 16'h000F},
    {1'b1, 8'h00, 8'h00, 16'h0130, 16'h0138, 16'h0010},
    {1'b0, 8'h03, 8'h01, 16'hFFFE, 16'h0200, 16'h0003},
    {1'b1, 8'h02, 8'h03, 16'h0001, 16'h0002, 16'h0002},
    {1'b0, 8'h01, 8'h01, 16'h0050, 16'h0060, 16'h0000}
  };

  task automatic fill_mem(input int seed);
    for (int i = 0; i < 4096; i++) begin
      mem[i]     = 8'((i * 7 + seed * 13 + (i >> 5)) & 8'hFF);
      ref_mem[i] = mem[i];
    end
  endtask

  task automatic run_move(input logic [64:0] v, input bit inject, input string tag);
    logic        d;
    logic [7:0]  sb, db;
    logic [15:0] x, y, c, ex, ey;
    int          mism, waitc;
    bit          got;
    {d, sb, db, x, y, c} = v;
    ex = x; ey = y;
    for (int k = 0; k <= int'(c); k++) begin
      ref_mem[idx(db, ey)] = ref_mem[idx(sb, ex)];
      ex = d ? ex - 16'd1 : ex + 16'd1;
      ey = d ? ey - 16'd1 : ey + 16'd1;
    end
    @(negedge clk);
    rd_cnt = 0; bank_err = 0; stall_err = 0;
    cur_sb = sb; cur_db = db;
    descend = d; src_bank = sb; dst_bank = db; x_in = x; y_in = y; c_in = c;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, {"R2 busy after start ", tag}, busy, 1);
    if (inject) begin
      repeat (3) @(negedge clk);
      descend = ~d; src_bank = 8'h02; dst_bank = 8'h00; x_in = 16'h0300; y_in = 16'h0310; c_in = 16'h0040;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    got = 0; waitc = 0;
    while (!got && waitc < 5000) begin
      if (done === 1'b1) got = 1;
      else begin @(negedge clk); waitc++; end
    end
    chk(got, {"R6 done seen ", tag}, got, 1);
    if (got) begin
      chk(busy === 1'b0, {"R6 busy low at done ", tag}, busy, 0);
      chk(x_out === ex, {"R7 x final ", tag}, x_out, ex);
      chk(y_out === ey, {"R7 y final ", tag}, y_out, ey);
      chk(c_out === 16'hFFFF, {"R7 c final ", tag}, c_out, 16'hFFFF);
      chk(dbank_out === db, {"R8 bank out ", tag}, dbank_out, db);
      chk(rd_cnt == int'(c) + 1, {"R5 byte count ", tag}, rd_cnt, int'(c) + 1);
      chk(first_rd === {sb, x}, {"R2 first read addr ", tag}, first_rd, {sb, x});
      chk(bank_err == 0, {"R11 bank kept ", tag}, bank_err, 0);
      chk(stall_err == 0, {"R9 stall hold ", tag}, stall_err, 0);
      mism = 0;
      for (int i = 0; i < 4096; i++) if (mem[i] !== ref_mem[i]) mism++;
      chk(mism == 0, {"R3 R4 memory image ", tag}, mism, 0);
      @(negedge clk);
      chk(done === 1'b0, {"R6 done one cycle ", tag}, done, 0);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    fill_mem(0);
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0, "R1 control idle", {busy, done, mem_req}, 0);
    chk(x_out === 16'h0 && y_out === 16'h0 && c_out === 16'h0 && dbank_out === 8'h0,
        "R1 outputs zero", {x_out, y_out}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_req === 1'b0, "R1 no request idle", mem_req, 0);
    for (int v = 0; v < NV; v++) begin
      fill_mem(v + 1);
      run_move(VEC[v], 1'b0, $sformatf("vec%0d", v));
    end
    // R10: start while busy is ignored
    fill_mem(9);
    run_move({1'b0, 8'h01, 8'h02, 16'h0010, 16'h0020, 16'h000B}, 1'b1, "R10 start ignored");
    // R5 single byte again, downward, at offset 0 wrapping (R11)
    fill_mem(11);
    run_move({1'b1, 8'h00, 8'h03, 16'h0000, 16'h0000, 16'h0000}, 1'b0, "R11 low wrap");
    finish_run();
  end
endmodule